// File: doc/BRIEF.md
# Dual-Channel Over-Range Flag Generator

This block watches two independent streams of signed 16-bit samples, channel A and channel B, and raises a registered flag per channel whenever a qualified sample lies beyond a programmable symmetric window. The window is pulled in from the two full-scale codes, +32767 and -32768, in steps of 128 codes. The 8-bit threshold setting gives the number of steps, so the window can shrink to about ±128 codes. A setting of zero keeps the rails themselves as the limits.

When a channel's samples come back inside the window, its flag can be stretched for a programmable number of clock cycles. This lets downstream gain control or logging see short bursts of clipping. Each channel has its own stretch counter, and one 2-bit hold setting serves both channels. The flags come straight from flip-flops, so each one reacts on the clock edge that captures the sample.

Top module: `ovr_detect_dual`

## Requirements
- R1: A synchronous active-high reset drives both flags low and cancels any hold in progress. Both flags read 0 on the first cycle after reset is released.
- R2: With a nonzero threshold field N, a valid sample is over range when it is greater than 32767 - 128*N or less than -32768 + 128*N.
- R3: A sample equal to either limit of R2 is not over range. A sample one code beyond either limit is over range.
- R4: With threshold field 0, only the two rail codes +32767 and -32768 count as over range.
- R5: A sample presented while its valid strobe is low does not change the flag and does not start or end a hold.
- R6: Hold field encoding is 0 for 0 cycles, 1 for 3 cycles, 2 for 7 cycles and 3 for 15 cycles. After the first valid in-range sample that follows an over-range condition, the flag stays high for exactly that many further clock cycles and then drops.
- R7: The hold counts every clock cycle, whether or not valid samples arrive. In-range samples that arrive during a hold do not restart it.
- R8: A valid over-range sample that arrives during a hold keeps the flag high and cancels the running count. A fresh full hold starts at the next valid in-range sample.
- R9: The two channels have independent detection and hold counting. The threshold and hold settings apply to both channels.
- R10: The hold length is captured when a hold starts. Changing the hold field during a hold affects only later holds.
- R11: The flag is registered. It goes high on the clock edge that captures a valid over-range sample and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| a_vld | input | 1 | Channel A sample qualifier |
| a_smp | input | 16 | Channel A sample, two's complement |
| b_vld | input | 1 | Channel B sample qualifier |
| b_smp | input | 16 | Channel B sample, two's complement |
| thr_field | input | 8 | Window pull-in, in 128-code steps |
| hold_sel | input | 2 | Hold length select |
| ovr_a | output | 1 | Channel A over-range flag |
| ovr_b | output | 1 | Channel B over-range flag |

## Verification
The bench probes the window edges exactly on each limit and one code beyond it. A design with the comparison off by one, or the wrong sign handling, would flag the limit itself or miss the first code past it. Setting zero is checked separately: a design that read it as a zero-width window would flag nearly every sample instead of only the rails. The bench measures hold pulse lengths for all four encodings, with the valid strobe both present and absent. It also checks a mid-hold reload, a mid-hold change of the hold field and the isolation between channels. A design that counted only valid samples, restarted on in-range data, or sampled the hold field each cycle would give the wrong pulse lengths.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int HOLD_SEL_W = 2;
  localparam int HOLD_CNT_W = 4;

  // hold select to cycle count: 0,3,7,15
  function automatic logic [HOLD_CNT_W-1:0] hold_cycles(input logic [HOLD_SEL_W-1:0] sel);
    logic [HOLD_CNT_W-1:0] n;
    case (sel)
      2'd0:    n = 4'd0;
      2'd1:    n = 4'd3;
      2'd2:    n = 4'd7;
      default: n = 4'd15;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/ovr_limits.sv
module ovr_limits #(
  parameter int DATA_W    = 16,
  parameter int THR_W     = 8,
  parameter int STEP_LOG2 = 7
) (
  input  logic [THR_W-1:0]         thr_field,
  output logic signed [DATA_W-1:0] hi_lim,
  output logic signed [DATA_W-1:0] lo_lim,
  output logic                     rail_mode
);
  localparam int PAD_W = DATA_W - THR_W - STEP_LOG2;
  localparam logic [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] pull_in;

  always_comb begin
    pull_in   = {{PAD_W{1'b0}}, thr_field, {STEP_LOG2{1'b0}}};
    hi_lim    = $signed(MAX_CODE - pull_in);
    lo_lim    = $signed(MIN_CODE + pull_in);
    rail_mode = (thr_field == '0);
  end
endmodule

// File: rtl/ovr_chan.sv
module ovr_chan
  import ovr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic signed [DATA_W-1:0] smp,
  input  logic signed [DATA_W-1:0] hi_lim,
  input  logic signed [DATA_W-1:0] lo_lim,
  input  logic                     rail_mode,
  input  logic [HOLD_SEL_W-1:0]    hold_sel,
  output logic                     flag
);
  localparam logic signed [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic                  beyond;
  logic                  hit;
  logic                  armed;
  logic [HOLD_CNT_W-1:0] remain;
  logic [HOLD_CNT_W-1:0] hold_len;

  always_comb begin
    if (rail_mode) beyond = (smp == MAX_CODE) || (smp == MIN_CODE);
    else           beyond = (smp > hi_lim) || (smp < lo_lim);
    hit      = vld && beyond;
    hold_len = hold_cycles(hold_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      armed  <= 1'b0;
      remain <= '0;
    end else if (hit) begin
      flag   <= 1'b1;
      armed  <= 1'b0;
      remain <= '0;
    end else if (flag && !armed && vld) begin
      if (hold_len == '0) begin
        flag <= 1'b0;
      end else begin
        armed  <= 1'b1;
        remain <= hold_len;
      end
    end else if (armed) begin
      if (remain == HOLD_CNT_W'(1)) begin
        flag   <= 1'b0;
        armed  <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  // R11
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  // R5
  rise_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit));

  // R8
  fall_without_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> !$past(hit));

  // R6
  zero_hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !armed && vld && !beyond && hold_sel == '0) |=> !flag);

  // R7
  hold_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !hit && remain > HOLD_CNT_W'(1)) |=> (armed && flag && remain == $past(remain) - 1'b1));
endmodule

// File: rtl/ovr_detect_dual.sv
module ovr_detect_dual
  import ovr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int THR_W     = 8,
  parameter int STEP_LOG2 = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  a_vld,
  input  logic [DATA_W-1:0]     a_smp,
  input  logic                  b_vld,
  input  logic [DATA_W-1:0]     b_smp,
  input  logic [THR_W-1:0]      thr_field,
  input  logic [HOLD_SEL_W-1:0] hold_sel,
  output logic                  ovr_a,
  output logic                  ovr_b
);
  localparam int NCH = 2;

  logic signed [DATA_W-1:0] hi_lim;
  logic signed [DATA_W-1:0] lo_lim;
  logic                     rail_mode;
  logic [NCH-1:0]           vld_v;
  logic [DATA_W-1:0]        smp_v [NCH];
  logic [NCH-1:0]           flag_v;

  ovr_limits #(.DATA_W(DATA_W), .THR_W(THR_W), .STEP_LOG2(STEP_LOG2)) u_limits (
    .thr_field (thr_field),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim),
    .rail_mode (rail_mode)
  );

  always_comb begin
    vld_v    = {b_vld, a_vld};
    smp_v[0] = a_smp;
    smp_v[1] = b_smp;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ovr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .vld       (vld_v[c]),
      .smp       ($signed(smp_v[c])),
      .hi_lim    (hi_lim),
      .lo_lim    (lo_lim),
      .rail_mode (rail_mode),
      .hold_sel  (hold_sel),
      .flag      (flag_v[c])
    );
  end

  assign ovr_a = flag_v[0];
  assign ovr_b = flag_v[1];
endmodule

// File: tb/tb_ovr_detect_dual.sv
module tb_ovr_detect_dual;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_vld = 1'b0, b_vld = 1'b0;
  logic [15:0] a_smp = '0, b_smp = '0;
  logic [7:0]  thr_field = '0;
  logic [1:0]  hold_sel = '0;
  logic        ovr_a, ovr_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_flag [2];
  int m_arm  [2];
  int m_cnt  [2];

  always #10 clk = ~clk;

  ovr_detect_dual dut (
    .clk(clk), .rst(rst), .a_vld(a_vld), .a_smp(a_smp), .b_vld(b_vld), .b_smp(b_smp),
    .thr_field(thr_field), .hold_sel(hold_sel), .ovr_a(ovr_a), .ovr_b(ovr_b)
  );

  function automatic int hold_of(int s);
    case (s)
      0: return 0;
      1: return 3;
      2: return 7;
      default: return 15;
    endcase
  endfunction

  function automatic bit is_beyond(logic [15:0] s, int n);
    int v;
    v = int'($signed(s));
    if (n == 0) return (v == 32767) || (v == -32768);
    return (v > 32767 - 128*n) || (v < -32768 + 128*n);
  endfunction

  task automatic model_tick(int ch, bit v, logic [15:0] s);
    if (rst) begin
      m_flag[ch] = 0; m_arm[ch] = 0; m_cnt[ch] = 0;
    end else if (v && is_beyond(s, int'(thr_field))) begin
      m_flag[ch] = 1; m_arm[ch] = 0; m_cnt[ch] = 0;
    end else if (m_flag[ch] == 1 && m_arm[ch] == 0 && v) begin
      if (hold_of(int'(hold_sel)) == 0) m_flag[ch] = 0;
      else begin m_arm[ch] = 1; m_cnt[ch] = hold_of(int'(hold_sel)); end
    end else if (m_arm[ch] == 1) begin
      if (m_cnt[ch] == 1) begin m_flag[ch] = 0; m_arm[ch] = 0; m_cnt[ch] = 0; end
      else m_cnt[ch] = m_cnt[ch] - 1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, land on the next negedge
  task automatic step(bit va, logic [15:0] sa, bit vb, logic [15:0] sb);
    a_vld = va; a_smp = sa; b_vld = vb; b_smp = sb;
    @(posedge clk);
    model_tick(0, va, sa);
    model_tick(1, vb, sb);
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 16'h0000, 1'b0, 16'h0000);
  endtask

  // over-range on A, then one in-range sample; count the stretch cycles
  task automatic pulse_a(input bit vld_in_hold, output int n);
    step(1'b1, 16'h7FFF, 1'b0, 16'h0);
    step(1'b1, 16'h0000, 1'b0, 16'h0);
    n = 0;
    while (ovr_a && n < 40) begin
      step(vld_in_hold, 16'h0010, 1'b0, 16'h0);
      n++;
    end
  endtask

  function automatic logic [15:0] pick(int n);
    int hi, lo, r;
    hi = (n == 0) ? 32767 : 32767 - 128*n;
    lo = (n == 0) ? -32768 : -32768 + 128*n;
    r  = int'($urandom % 7);
    case (r)
      0: return 16'(hi);
      1: return 16'(hi + 1);
      2: return 16'(lo);
      3: return 16'(lo - 1);
      4: return 16'h7FFF;
      5: return 16'h8000;
      default: return 16'(int'($urandom % 512) - 256);
    endcase
  endfunction

  initial begin
    int n;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    m_flag = '{0, 0}; m_arm = '{0, 0}; m_cnt = '{0, 0};
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset ovr_a", int'(ovr_a), 0);
    check("R1 reset ovr_b", int'(ovr_b), 0);

    // R2 R3: N=1, limits +32639 / -32640
    thr_field = 8'd1; hold_sel = 2'd0;
    step(1'b1, 16'(32639), 1'b1, 16'(-32640));
    check("R3 on hi limit", int'(ovr_a), 0);
    check("R3 on lo limit", int'(ovr_b), 0);
    step(1'b1, 16'(32640), 1'b1, 16'(-32641));
    check("R3 one past hi", int'(ovr_a), 1);
    check("R2 one past lo", int'(ovr_b), 1);
    step(1'b1, 16'h0, 1'b1, 16'h0);
    check("R6 zero hold drop", int'(ovr_a), 0);

    // R2: N=255, window +127 / -128
    thr_field = 8'd255;
    step(1'b1, 16'(128), 1'b1, 16'(127));
    check("R2 N255 above", int'(ovr_a), 1);
    check("R2 N255 on limit", int'(ovr_b), 0);
    step(1'b1, 16'h0, 1'b1, 16'(-129));
    check("R2 N255 below", int'(ovr_b), 1);
    step(1'b1, 16'h0, 1'b1, 16'h0);

    // R4 rail mode
    thr_field = 8'd0;
    step(1'b1, 16'(32766), 1'b1, 16'(-32767));
    check("R4 near rail hi", int'(ovr_a), 0);
    check("R4 near rail lo", int'(ovr_b), 0);
    step(1'b1, 16'h7FFF, 1'b1, 16'h8000);
    check("R4 rail hi", int'(ovr_a), 1);
    check("R4 rail lo", int'(ovr_b), 1);
    step(1'b1, 16'h0, 1'b1, 16'h0);

    // R5 invalid samples ignored
    step(1'b0, 16'h7FFF, 1'b0, 16'h8000);
    check("R5 invalid over", int'(ovr_a), 0);
    check("R5 invalid over b", int'(ovr_b), 0);
    step(1'b1, 16'h7FFF, 1'b0, 16'h0);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    check("R5 invalid in-range keeps flag", int'(ovr_a), 1);
    step(1'b1, 16'h0, 1'b0, 16'h0);
    check("R11 flag drop", int'(ovr_a), 0);

    // R11 registered timing
    a_vld = 1'b1; a_smp = 16'h7FFF;
    #1;
    check("R11 not combinational", int'(ovr_a), 0);
    @(posedge clk); model_tick(0, 1'b1, 16'h7FFF); model_tick(1, 1'b0, 16'h0);
    @(negedge clk);
    check("R11 after edge", int'(ovr_a), 1);
    step(1'b1, 16'h0, 1'b0, 16'h0);

    // R6 hold lengths, R7 without valid samples
    for (int s = 0; s < 4; s++) begin
      hold_sel = 2'(s);
      pulse_a(1'b0, n);
      check($sformatf("R6 hold sel %0d", s), n, hold_of(s));
    end
    // R7 in-range valid samples do not restart
    hold_sel = 2'd2;
    pulse_a(1'b1, n);
    check("R7 hold with valid in-range", n, 7);

    // R8 reload during hold
    hold_sel = 2'd1;
    step(1'b1, 16'h7FFF, 1'b0, 16'h0);
    step(1'b1, 16'h0, 1'b0, 16'h0);
    idle();
    step(1'b1, 16'h7FFF, 1'b0, 16'h0);
    idle(); idle(); idle(); idle();
    check("R8 reload keeps flag", int'(ovr_a), 1);
    step(1'b1, 16'h0, 1'b0, 16'h0);
    n = 0;
    while (ovr_a && n < 40) begin idle(); n++; end
    check("R8 fresh hold length", n, 3);

    // R10 hold change mid-hold
    hold_sel = 2'd3;
    step(1'b1, 16'h7FFF, 1'b0, 16'h0);
    step(1'b1, 16'h0, 1'b0, 16'h0);
    hold_sel = 2'd0;
    n = 0;
    while (ovr_a && n < 40) begin idle(); n++; end
    check("R10 captured hold", n, 15);
    pulse_a(1'b0, n);
    check("R10 next hold uses new value", n, 0);

    // R9 independence
    hold_sel = 2'd1;
    step(1'b1, 16'h7FFF, 1'b1, 16'h0);
    check("R9 B untouched", int'(ovr_b), 0);
    step(1'b1, 16'h0, 1'b1, 16'h8000);
    idle();
    check("R9 A in hold", int'(ovr_a), 1);
    check("R9 B set", int'(ovr_b), 1);
    idle(); idle();
    check("R9 A dropped", int'(ovr_a), 0);
    check("R9 B still held", int'(ovr_b), 1);
    step(1'b0, 16'h0, 1'b1, 16'h0);
    idle(); idle();
    check("R9 B in own hold", int'(ovr_b), 1);
    idle();
    check("R9 B dropped", int'(ovr_b), 0);

    // R1 reset mid-hold
    hold_sel = 2'd3;
    step(1'b1, 16'h7FFF, 1'b1, 16'h8000);
    step(1'b1, 16'h0, 1'b1, 16'h0);
    rst = 1'b1;
    idle();
    rst = 1'b0;
    check("R1 reset clears a", int'(ovr_a), 0);
    check("R1 reset clears b", int'(ovr_b), 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 50 == 0) begin
        thr_field = ($urandom % 3 == 0) ? 8'd0 : 8'($urandom);
        hold_sel  = 2'($urandom);
      end
      if (i % 13 == 7) hold_sel = 2'($urandom);
      step(1'($urandom), pick(int'(thr_field)), 1'($urandom), pick(int'(thr_field)));
      check("R2 R6 R8 random ovr_a", int'(ovr_a), m_flag[0]);
      check("R2 R6 R9 random ovr_b", int'(ovr_b), m_flag[1]);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule